// File: doc/BRIEF.md
# Processor Bus Glue and Interrupt Level Encoder

This block sits between a processor bus with 16-bit data and 24-bit addresses and a memory system built from separate byte-wide devices. The bus carries address bits 23 down to 1 and no bit 0. Instead, an upper data strobe selects the D15..D8 byte lane and a lower data strobe selects the D7..D0 lane. From the address, the address strobe, the two data strobes and the read/write line, the block decodes four active-low chip selects: ROM high lane, ROM low lane, RAM high lane and RAM low lane. It also produces active-low read and write strobes and an active-high select for an I/O window. All of these paths are combinational, and all of them are gated by the address strobe.

The block also turns seven active-low interrupt request lines into a three-bit active-low priority level for the processor. Request line 7 has the highest priority. The request lines are asynchronous, so they pass through a two-flop synchronizer before the priority encoder.

Top module: `bus_glue`

## Requirements
- R1: While `asN` is high, every chip select, `rdStrbN` and `wrStrbN` stay high and `ioSel` stays low, whatever the address, data strobes and `rdWr` are.
- R2: With `asN` low, `rdStrbN` is low exactly when `rdWr` is 1 and `wrStrbN` is low exactly when `rdWr` is 0; the two are never low together.
- R3: For byte addresses 000000h..03FFFFh with `asN` low, `romHiSelN` is low exactly when `udsN` is low and `romLoSelN` is low exactly when `ldsN` is low; no RAM select asserts.
- R4: For byte addresses 100000h..13FFFFh with `asN` low, `ramHiSelN` follows `udsN` and `ramLoSelN` follows `ldsN` in the same way; no ROM select asserts.
- R5: Addresses outside both memory regions (for example 040000h, 0FFFFEh, 140000h) assert no chip select.
- R6: `ioSel` is high only while `asN` is low and the byte address (`busAddr` with a 0 appended as bit 0) lies in F00000h..FFFFFFh by default.
- R7: `iplN` equals the bitwise inverse of the number of the highest asserted request: bit k-1 of `intReqN` is request k, active low. Request 7 gives `iplN` = 000 and request 6 alone gives 001.
- R8: A lower request asserted or released while a higher one is held leaves `iplN` unchanged.
- R9: With no request asserted, and throughout reset, `iplN` is 111.
- R10: A change on `intReqN` made between clock edges shows on `iplN` after the second rising edge and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the interrupt synchronizer |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 23 | Address bits 23..1 |
| asN | input | 1 | Address strobe, active low |
| udsN | input | 1 | Upper byte lane strobe, active low |
| ldsN | input | 1 | Lower byte lane strobe, active low |
| rdWr | input | 1 | 1 = read cycle, 0 = write cycle |
| intReqN | input | 7 | Interrupt requests 1..7 on bits 0..6, active low |
| romHiSelN | output | 1 | ROM upper lane chip select, active low |
| romLoSelN | output | 1 | ROM lower lane chip select, active low |
| ramHiSelN | output | 1 | RAM upper lane chip select, active low |
| ramLoSelN | output | 1 | RAM lower lane chip select, active low |
| rdStrbN | output | 1 | Read strobe, active low |
| wrStrbN | output | 1 | Write strobe, active low |
| ioSel | output | 1 | I/O window select, active high |
| iplN | output | 3 | Priority level, inverted binary |

## Verification
The decoder is tested with word, upper-byte and lower-byte accesses at both ends of each memory region and just past them. This separates lane errors from region-boundary errors. The same memory addresses are also presented with the address strobe negated, to show that the strobe gates every output. The encoder is tested with a single low request, then with stacked requests that are added and removed around a higher one, to tell a priority error from a plain encoding error. Each interrupt step is sampled both one and two clock edges after the input changes, which pins down the synchronizer depth.

// File: rtl/bus_glue_pkg.sv
package bus_glue_pkg;
  parameter int ADDR_W  = 24;
  parameter int NUM_LVL = 7;
  localparam int LVL_W  = $clog2(NUM_LVL + 1);

  typedef struct packed {
    logic romHit;
    logic ramHit;
    logic ioHit;
    logic rdEn;
    logic wrEn;
  } glueStrb_t;
endpackage

// File: rtl/glue_ctrl.sv
module glue_ctrl
  import bus_glue_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ROM_BASE = 24'h000000,
  parameter logic [ADDR_W-1:0] ROM_LAST = 24'h03FFFF,
  parameter logic [ADDR_W-1:0] RAM_BASE = 24'h100000,
  parameter logic [ADDR_W-1:0] RAM_LAST = 24'h13FFFF,
  parameter logic [ADDR_W-1:0] IO_BASE  = 24'hF00000,
  parameter logic [ADDR_W-1:0] IO_LAST  = 24'hFFFFFF
) (
  input  logic [ADDR_W-1:1] busAddr,
  input  logic              asN,
  input  logic              rdWr,
  output glueStrb_t         strb
);
  localparam logic [ADDR_W-1:0] ROM_SPAN = ROM_LAST - ROM_BASE;
  localparam logic [ADDR_W-1:0] RAM_SPAN = RAM_LAST - RAM_BASE;
  localparam logic [ADDR_W-1:0] IO_SPAN  = IO_LAST - IO_BASE;

  logic [ADDR_W-1:0] byteAddr;
  logic [ADDR_W-1:0] romOfs, ramOfs, ioOfs;
  logic romWin, ramWin, ioWin, cycOn;

  // The offset from each base is compared once against the span, unsigned.
  always_comb begin
    byteAddr = {busAddr, 1'b0};
    romOfs   = byteAddr - ROM_BASE;
    ramOfs   = byteAddr - RAM_BASE;
    ioOfs    = byteAddr - IO_BASE;
    romWin   = (romOfs <= ROM_SPAN);
    ramWin   = (ramOfs <= RAM_SPAN);
    ioWin    = (ioOfs <= IO_SPAN);
    cycOn    = ~asN;

    strb.romHit = cycOn & romWin;
    strb.ramHit = cycOn & ramWin & ~romWin;
    strb.ioHit  = cycOn & ioWin & ~romWin & ~ramWin;
    strb.rdEn   = cycOn & rdWr;
    strb.wrEn   = cycOn & ~rdWr;
  end
endmodule

// File: rtl/glue_dp.sv
module glue_dp
  import bus_glue_pkg::*;
(
  input  glueStrb_t strb,
  input  logic      udsN,
  input  logic      ldsN,
  output logic      romHiSelN,
  output logic      romLoSelN,
  output logic      ramHiSelN,
  output logic      ramLoSelN,
  output logic      rdStrbN,
  output logic      wrStrbN,
  output logic      ioSel
);
  // Index 0 = upper lane, 1 = lower lane.
  logic [1:0] laneOn;
  logic [1:0] romSel, ramSel;

  assign laneOn = {~ldsN, ~udsN};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign romSel[g] = strb.romHit & laneOn[g];
    assign ramSel[g] = strb.ramHit & laneOn[g];
  end

  assign romHiSelN = ~romSel[0];
  assign romLoSelN = ~romSel[1];
  assign ramHiSelN = ~ramSel[0];
  assign ramLoSelN = ~ramSel[1];
  assign rdStrbN   = ~strb.rdEn;
  assign wrStrbN   = ~strb.wrEn;
  assign ioSel     = strb.ioHit;
endmodule

// File: rtl/irq_enc.sv
module irq_enc
  import bus_glue_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_LVL-1:0] intReqN,
  output logic [LVL_W-1:0]   iplN
);
  logic [NUM_LVL-1:0] syncA, syncB;
  logic [LVL_W-1:0]   lvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '1;
      syncB <= '1;
    end else begin
      syncA <= intReqN;
      syncB <= syncA;
    end
  end

  // The scan runs upward, so the highest asserted request is the last one to write lvl.
  always_comb begin
    lvl = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (!syncB[i]) lvl = LVL_W'(i + 1);
    end
  end

  assign iplN = ~lvl;
endmodule

// File: rtl/bus_glue.sv
module bus_glue
  import bus_glue_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:1]  busAddr,
  input  logic               asN,
  input  logic               udsN,
  input  logic               ldsN,
  input  logic               rdWr,
  input  logic [NUM_LVL-1:0] intReqN,
  output logic               romHiSelN,
  output logic               romLoSelN,
  output logic               ramHiSelN,
  output logic               ramLoSelN,
  output logic               rdStrbN,
  output logic               wrStrbN,
  output logic               ioSel,
  output logic [LVL_W-1:0]   iplN
);
  glueStrb_t strb;

  glue_ctrl u_ctrl (
    .busAddr(busAddr), .asN(asN), .rdWr(rdWr), .strb(strb)
  );

  glue_dp u_dp (
    .strb(strb), .udsN(udsN), .ldsN(ldsN),
    .romHiSelN(romHiSelN), .romLoSelN(romLoSelN),
    .ramHiSelN(ramHiSelN), .ramLoSelN(ramLoSelN),
    .rdStrbN(rdStrbN), .wrStrbN(wrStrbN), .ioSel(ioSel)
  );

  irq_enc u_irq (
    .clk(clk), .rstN(rstN), .intReqN(intReqN), .iplN(iplN)
  );
endmodule

// File: rtl/bus_glue_chk.sv
module bus_glue_chk (
  input logic        clk,
  input logic        rstN,
  input logic [23:1] busAddr,
  input logic        asN,
  input logic        udsN,
  input logic        ldsN,
  input logic        rdWr,
  input logic [6:0]  intReqN,
  input logic        romHiSelN,
  input logic        romLoSelN,
  input logic        ramHiSelN,
  input logic        ramLoSelN,
  input logic        rdStrbN,
  input logic        wrStrbN,
  input logic        ioSel,
  input logic [2:0]  iplN
);
  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) upCnt <= '0;
    else if (upCnt != 2'd2) upCnt <= upCnt + 2'd1;
  end

  function automatic logic [2:0] expIpl(input logic [6:0] r);
    for (int i = 6; i >= 0; i--) begin
      if (!r[i]) return ~3'(i + 1);
    end
    return 3'b111;
  endfunction

  logic inRom, inRam;
  assign inRom = (busAddr[23:18] == 6'b000000);
  assign inRam = (busAddr[23:18] == 6'b000100);

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    asN |-> (romHiSelN && romLoSelN && ramHiSelN && ramLoSelN && rdStrbN && wrStrbN && !ioSel));

  p_strobe_dir_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrbN |-> (!asN && rdWr && wrStrbN));

  p_rom_lane_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!romHiSelN || !romLoSelN) |-> (inRom && (romHiSelN == udsN) && (romLoSelN == ldsN)));

  p_ram_lane_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ramHiSelN || !ramLoSelN) |-> (inRam && (ramHiSelN == udsN) && (ramLoSelN == ldsN)));

  p_one_target_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones({!romHiSelN || !romLoSelN, !ramHiSelN || !ramLoSelN, ioSel}) <= 1);

  p_io_win_r6: assert property (@(posedge clk) disable iff (!rstN)
    ioSel |-> (!asN && busAddr[23:20] == 4'hF));

  p_ipl_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd2) |-> (iplN == expIpl($past(intReqN, 2))));

  p_top_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((upCnt == 2'd2) && !$past(intReqN[6], 2)) |-> (iplN == 3'b000));
endmodule

bind bus_glue bus_glue_chk u_chk (.*);

// File: tb/sim_bus_glue.sv
module sim_bus_glue;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:1] busAddr = '0;
  logic        asN = 1'b1, udsN = 1'b1, ldsN = 1'b1, rdWr = 1'b1;
  logic [6:0]  intReqN = 7'h7F;
  logic romHiSelN, romLoSelN, ramHiSelN, ramLoSelN, rdStrbN, wrStrbN, ioSel;
  logic [2:0]  iplN;

  always #10 clk = ~clk;

  bus_glue u0 (.*);

  typedef struct {
    string      req;
    bit         isIrq;
    logic [6:0] expBus;
    logic [2:0] expIpl;
  } item_t;

  item_t q[$];
  int nRun = 0, nFail = 0;
  bit done = 0;

  // Bus bits: {romHi, romLo, ramHi, ramLo, rd, wr, io}.
  function automatic logic [6:0] model(input logic [23:0] a, input logic as_n,
                                       input logic u_n, input logic l_n, input logic rw);
    logic rom, ram, io;
    rom = (a <= 24'h03FFFF);
    ram = (a >= 24'h100000) && (a <= 24'h13FFFF);
    io  = (a >= 24'hF00000);
    if (as_n) return 7'b1111110;
    return {~(rom & ~u_n), ~(rom & ~l_n), ~(ram & ~u_n), ~(ram & ~l_n), ~rw, rw, io};
  endfunction

  task automatic busCyc(input string req, input logic [23:0] a, input logic as_n,
                        input logic u_n, input logic l_n, input logic rw);
    item_t it;
    @(negedge clk);
    busAddr = a[23:1]; asN = as_n; udsN = u_n; ldsN = l_n; rdWr = rw;
    it.req = req; it.isIrq = 0; it.expBus = model(a, as_n, u_n, l_n, rw); it.expIpl = '0;
    q.push_back(it);
  endtask

  task automatic irqStep(input string req, input logic [6:0] r, input logic [2:0] oldIpl,
                         input logic [2:0] newIpl);
    item_t it;
    @(negedge clk);
    intReqN = r;
    @(negedge clk);
    it.req = {req, " R10 one edge"}; it.isIrq = 1; it.expBus = '0; it.expIpl = oldIpl;
    q.push_back(it);
    @(negedge clk);
    it.req = req; it.expIpl = newIpl;
    q.push_back(it);
  endtask

  // Monitor: samples mid low phase, after the driver has settled.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        nRun++;
        if (it.isIrq) begin
          if (iplN !== it.expIpl) begin
            nFail++;
            $display("FAIL %s: iplN=%b expected %b", it.req, iplN, it.expIpl);
          end
        end else begin
          if ({romHiSelN, romLoSelN, ramHiSelN, ramLoSelN, rdStrbN, wrStrbN, ioSel} !== it.expBus) begin
            nFail++;
            $display("FAIL %s: bus=%b expected %b", it.req,
              {romHiSelN, romLoSelN, ramHiSelN, ramLoSelN, rdStrbN, wrStrbN, ioSel}, it.expBus);
          end
        end
      end
    end
  end

  initial begin
    item_t it;
    // Reset state (R9, R1)
    @(negedge clk);
    it.req = "R9 reset ipl"; it.isIrq = 1; it.expBus = '0; it.expIpl = 3'b111; q.push_back(it);
    it.req = "R1 reset bus"; it.isIrq = 0; it.expBus = 7'b1111110; q.push_back(it);
    @(negedge clk);
    rstN = 1'b1;

    busCyc("R1 strobe off rom", 24'h000100, 1, 0, 0, 1);
    busCyc("R1 strobe off io",  24'hF00000, 1, 0, 0, 0);
    busCyc("R3 rom word read",  24'h000100, 0, 0, 0, 1);
    busCyc("R3 rom upper",      24'h03FFFE, 0, 0, 1, 1);
    busCyc("R3 rom lower",      24'h03FFFE, 0, 1, 0, 1);
    busCyc("R2 rom write",      24'h000000, 0, 0, 0, 0);
    busCyc("R4 ram word write", 24'h100000, 0, 0, 0, 0);
    busCyc("R4 ram lower",      24'h13FFFE, 0, 1, 0, 1);
    busCyc("R4 ram upper",      24'h120000, 0, 0, 1, 0);
    busCyc("R5 past rom",       24'h040000, 0, 0, 0, 1);
    busCyc("R5 below ram",      24'h0FFFFE, 0, 0, 0, 1);
    busCyc("R5 past ram",       24'h140000, 0, 0, 0, 0);
    busCyc("R6 io base",        24'hF00000, 0, 0, 0, 1);
    busCyc("R6 io top",         24'hFFFFFE, 0, 1, 0, 0);
    busCyc("R6 below io",       24'hEFFFFE, 0, 0, 0, 1);
    busCyc("R2 no lane read",   24'h200000, 0, 1, 1, 1);
    busCyc("R1 idle",           24'h100000, 1, 1, 1, 0);

    irqStep("R7 int1 only",         7'b1111110, 3'b111, 3'b110);
    irqStep("R9 none",              7'b1111111, 3'b110, 3'b111);
    irqStep("R7 int6 only",         7'b1011111, 3'b111, 3'b001);
    irqStep("R8 int5 under int6",   7'b1001111, 3'b001, 3'b001);
    irqStep("R7 int7 top",          7'b0001111, 3'b001, 3'b000);
    irqStep("R8 int1 under int7",   7'b0001110, 3'b000, 3'b000);
    irqStep("R7 drop int7",         7'b1001110, 3'b000, 3'b001);
    irqStep("R9 release all",       7'b1111111, 3'b001, 3'b111);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      nRun++; nFail++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule